// File: doc/BRIEF.md
# Multi-Source Acquisition Trigger Controller

This block decides when a multi-channel sample recorder begins storing data and how long it keeps storing. Three unlike trigger sources feed it: a rising level crossing on one selected input channel, compared against a programmable threshold; a rising edge on an asynchronous external logic input; and a software trigger command. A three-bit enable mask decides which of them may fire.

Control follows a fixed arm, capture and done sequence. A host command arms the controller; the first enabled trigger starts a capture window that lasts for a programmable number of valid samples. The controller then reports done and waits for a fresh arm command. An abort command returns it to idle from any state. The counter is wide enough for records of a billion samples and beyond. Sample storage, converter capture and host transport sit outside the block.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: Throughout reset and immediately after it, `capture_en` and `done` are low, `trig_src` is 0 and `sample_count` is 0. `capture_en` and `done` are never high together.
- R2: Triggers are accepted only after an arm command (`cmd_code` 1). In idle, a software trigger does not start a capture.
- R3: A level trigger fires on a valid sample of channel `chan_sel` (bits `chan_sel*SAMPLE_W` upward in `sample_data`) when the previous valid sample was at or below `threshold` and the current one is above it. A sample equal to the threshold, or a crossing on an unselected channel, does not fire. It reports `trig_src` 1.
- R4: A rising edge on `ext_trig_in` passes through two synchroniser flops and an edge detector. When driven just after a clock edge while armed, `capture_en` rises on the third following clock edge. It reports `trig_src` 2.
- R5: A software trigger (`cmd_code` 2 with `cmd_valid`) starts a capture on the next edge and reports `trig_src` 3.
- R6: A source whose `src_enable` bit is clear (bit 0 level, bit 1 external, bit 2 software) cannot start a capture.
- R7: When several enabled sources fire in the same cycle, `trig_src` records the winner in the order software, then external, then level.
- R8: `capture_en` stays high for exactly `record_len` valid samples (0 is treated as 1). `sample_count` advances only on valid samples and ends equal to the length. `LEN_W` defaults to 30 bits, which holds 10^9.
- R9: After a capture, `done` stays high and no trigger starts a new capture until an arm command is received.
- R10: An abort command (`cmd_code` 3) returns the controller to idle from any state. On the next edge it clears `capture_en`, `done`, `trig_src` and `sample_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_data | input | NUM_CH*SAMPLE_W | Packed samples, channel 0 in the low bits |
| sample_valid | input | 1 | Qualifies `sample_data` this cycle |
| chan_sel | input | CH_W | Channel watched by the level trigger |
| threshold | input | SAMPLE_W | Level trigger threshold |
| ext_trig_in | input | 1 | Asynchronous external trigger |
| src_enable | input | 3 | Source mask: bit0 level, bit1 external, bit2 software |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 none, 1 arm, 2 software trigger, 3 abort |
| record_len | input | LEN_W | Capture length in valid samples |
| capture_en | output | 1 | High while the record window is open |
| done | output | 1 | Capture finished, awaiting re-arm |
| trig_src | output | 2 | 0 none, 1 level, 2 external, 3 software |
| sample_count | output | LEN_W | Valid samples captured so far |

## Verification
Two kinds of collision can happen in one armed cycle. The first is a software command, a synchronised external edge and a level crossing all arriving together. The bench raises the external input two edges ahead so that its detected edge lines up with a software command and a crossing sample, and then expects the software code. It repeats the test without the software command and then expects the external code. The second collision is an abort landing in the middle of a capture window. It must close the window without the scoreboard seeing a completed record, and it must clear the counter.

// File: rtl/acq_trig_pkg.sv
// Package: shared encodings for the acquisition trigger controller.
// Assumes: command and source codes are fixed two-bit values seen by software.
package acq_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } acq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_SW    = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'd0,
        CMD_ARM    = 2'd1,
        CMD_SWTRIG = 2'd2,
        CMD_ABORT  = 2'd3
    } cmd_e;

    localparam int EN_LEVEL = 0;
    localparam int EN_EXT   = 1;
    localparam int EN_SW    = 2;
    localparam int NUM_SRC  = 3;

endpackage

// File: rtl/ext_edge_sync.sv
// Module: ext_edge_sync
// Brings an asynchronous level into the clock domain through SYNC_STAGES
// flops and emits a one-cycle pulse on each rising edge.
// Assumes: input pulses last longer than two clock periods.
module ext_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the input through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], async_in};
        end
    end

    assign rise_pulse = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

endmodule

// File: rtl/level_cross_detect.sv
// Module: level_cross_detect
// Watches one selected channel and flags a rising threshold crossing:
// previous valid sample <= threshold and current valid sample > threshold.
// Assumes: chan_sel is held steady while armed; a change makes the first
// comparison use the previous channel's sample as history.
module level_cross_detect #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 10,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_data,
    input  logic                       sample_valid,
    input  logic [CH_W-1:0]            chan_sel,
    input  logic [SAMPLE_W-1:0]        threshold,
    output logic                       cross_hit
);
    logic [SAMPLE_W-1:0] ch_val [NUM_CH];
    logic [SAMPLE_W-1:0] cur_val;
    logic [SAMPLE_W-1:0] prev_q;
    logic                prev_ok_q;

    // Unpack the channel bus into one slice per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign ch_val[g] = sample_data[g*SAMPLE_W +: SAMPLE_W];
    end

    assign cur_val = ch_val[chan_sel];

    // Remember the last valid sample of the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else if (sample_valid) begin
            prev_q    <= cur_val;
            prev_ok_q <= 1'b1;
        end
    end

    assign cross_hit = sample_valid && prev_ok_q &&
                       (prev_q <= threshold) && (cur_val > threshold);

endmodule

// File: rtl/capture_sequencer.sv
// Module: capture_sequencer
// Arm / capture / done state machine with a fixed source priority and a
// record-length counter that counts valid samples only.
// Assumes: record_len is held steady during a capture; 0 acts as 1.
module capture_sequencer
    import acq_trig_pkg::*;
#(
    parameter int LEN_W = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_hit,
    input  logic               ext_hit,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_code,
    input  logic [NUM_SRC-1:0] src_enable,
    input  logic [LEN_W-1:0]   record_len,
    input  logic               sample_valid,
    output acq_state_e         state,
    output trig_src_e          trig_src,
    output logic [LEN_W-1:0]   sample_count,
    output logic               capture_en,
    output logic               done
);
    logic       arm_cmd, abort_cmd, sw_cmd;
    logic       last_sample;
    logic [LEN_W-1:0] len_m1;
    trig_src_e  winner;

    assign arm_cmd   = cmd_valid && (cmd_code == CMD_ARM);
    assign abort_cmd = cmd_valid && (cmd_code == CMD_ABORT);
    assign sw_cmd    = cmd_valid && (cmd_code == CMD_SWTRIG);
    assign len_m1    = (record_len == '0) ? '0 : record_len - 1'b1;
    assign last_sample = (sample_count == len_m1);

    // Pick the highest-priority enabled source firing this cycle.
    always_comb begin
        if (sw_cmd && src_enable[EN_SW])
            winner = SRC_SW;
        else if (ext_hit && src_enable[EN_EXT])
            winner = SRC_EXT;
        else if (level_hit && src_enable[EN_LEVEL])
            winner = SRC_LEVEL;
        else
            winner = SRC_NONE;
    end

    // Advance the sequence, latch the trigger source and count samples.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_cmd) begin
            state        <= ST_IDLE;
            trig_src     <= SRC_NONE;
            sample_count <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (arm_cmd) begin
                        state        <= ST_ARMED;
                        trig_src     <= SRC_NONE;
                        sample_count <= '0;
                    end
                end
                ST_ARMED: begin
                    if (winner != SRC_NONE) begin
                        state        <= ST_CAPTURE;
                        trig_src     <= winner;
                        sample_count <= '0;
                    end
                end
                ST_CAPTURE: begin
                    if (sample_valid) begin
                        sample_count <= sample_count + 1'b1;
                        if (last_sample)
                            state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign capture_en = (state == ST_CAPTURE);
    assign done       = (state == ST_DONE);

endmodule

// File: rtl/acq_trigger_ctrl.sv
// Module: acq_trigger_ctrl (top)
// Merges a level-crossing trigger, a synchronised external edge and a
// software command under one arm / capture / done sequence.
// Assumes: all inputs except ext_trig_in are synchronous to clk.
module acq_trigger_ctrl
    import acq_trig_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SAMPLE_W    = 10,
    parameter int LEN_W       = 30,
    parameter int SYNC_STAGES = 2,
    parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_data,
    input  logic                       sample_valid,
    input  logic [CH_W-1:0]            chan_sel,
    input  logic [SAMPLE_W-1:0]        threshold,
    input  logic                       ext_trig_in,
    input  logic [2:0]                 src_enable,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_code,
    input  logic [LEN_W-1:0]           record_len,
    output logic                       capture_en,
    output logic                       done,
    output logic [1:0]                 trig_src,
    output logic [LEN_W-1:0]           sample_count
);
    logic       level_hit;
    logic       ext_hit;
    acq_state_e fsm_state;
    trig_src_e  src_q;

    level_cross_detect #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .CH_W     (CH_W)
    ) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .chan_sel     (chan_sel),
        .threshold    (threshold),
        .cross_hit    (level_hit)
    );

    ext_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_trig_in),
        .rise_pulse (ext_hit)
    );

    capture_sequencer #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_hit    (level_hit),
        .ext_hit      (ext_hit),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .src_enable   (src_enable),
        .record_len   (record_len),
        .sample_valid (sample_valid),
        .state        (fsm_state),
        .trig_src     (src_q),
        .sample_count (sample_count),
        .capture_en   (capture_en),
        .done         (done)
    );

    assign trig_src = src_q;

endmodule

// File: rtl/acq_trigger_ctrl_checker.sv
// Module: acq_trigger_ctrl_checker
// Temporal properties of the trigger controller, bound to the top module.
// Assumes: record_len is steady while a capture is open.
module acq_trigger_ctrl_checker
    import acq_trig_pkg::*;
#(
    parameter int LEN_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_code,
    input logic [2:0]       src_enable,
    input logic             sample_valid,
    input logic [LEN_W-1:0] record_len,
    input logic             capture_en,
    input logic             done,
    input logic [1:0]       trig_src,
    input logic [LEN_W-1:0] sample_count,
    input acq_state_e       state
);
    logic             is_abort, is_arm, is_sw;
    logic [LEN_W-1:0] eff_len;

    assign is_abort = cmd_valid && (cmd_code == CMD_ABORT);
    assign is_arm   = cmd_valid && (cmd_code == CMD_ARM);
    assign is_sw    = cmd_valid && (cmd_code == CMD_SWTRIG);
    assign eff_len  = (record_len == '0) ? {{(LEN_W-1){1'b0}}, 1'b1} : record_len;

    a_r1_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture_en && done));

    a_r2_start_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture_en) |-> ($past(state) == ST_ARMED));

    a_r7_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && is_sw && src_enable[EN_SW]) |=>
        (capture_en && trig_src == SRC_SW));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |-> (sample_count < eff_len));

    a_r8_hold_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !sample_valid && !is_abort) |=> $stable(sample_count));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_arm && !is_abort) |=> done);

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        is_abort |=> (state == ST_IDLE && !capture_en && !done &&
                      trig_src == SRC_NONE && sample_count == '0));

endmodule

bind acq_trigger_ctrl acq_trigger_ctrl_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .src_enable   (src_enable),
    .sample_valid (sample_valid),
    .record_len   (record_len),
    .capture_en   (capture_en),
    .done         (done),
    .trig_src     (trig_src),
    .sample_count (sample_count),
    .state        (fsm_state)
);

// File: tb/acq_trigger_ctrl_test.sv
// Scoreboard bench: driver tasks queue expected captures, a monitor closes them.
module acq_trigger_ctrl_test;
    localparam int NUM_CH   = 4;
    localparam int SAMPLE_W = 10;
    localparam int LEN_W    = 30;
    localparam int CH_W     = 2;

    localparam logic [1:0] C_ARM = 2'd1, C_SW = 2'd2, C_ABORT = 2'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                       rst_n;
    logic [NUM_CH*SAMPLE_W-1:0] sample_data;
    logic                       sample_valid;
    logic [CH_W-1:0]            chan_sel;
    logic [SAMPLE_W-1:0]        threshold;
    logic                       ext_trig_in;
    logic [2:0]                 src_enable;
    logic                       cmd_valid;
    logic [1:0]                 cmd_code;
    logic [LEN_W-1:0]           record_len;
    logic                       capture_en, done;
    logic [1:0]                 trig_src;
    logic [LEN_W-1:0]           sample_count;

    acq_trigger_ctrl #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .sample_data(sample_data),
        .sample_valid(sample_valid), .chan_sel(chan_sel), .threshold(threshold),
        .ext_trig_in(ext_trig_in), .src_enable(src_enable), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .record_len(record_len), .capture_en(capture_en),
        .done(done), .trig_src(trig_src), .sample_count(sample_count)
    );

    typedef struct {
        string      req;
        logic [1:0] src;
        int         len;
    } cap_item_t;

    cap_item_t exp_q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_capture(string req, logic [1:0] src, int len);
        cap_item_t it;
        it.req = req; it.src = src; it.len = len;
        exp_q.push_back(it);
    endtask

    task automatic send_cmd(logic [1:0] code);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_code = code;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_code = 2'd0;
    endtask

    task automatic set_ch(int idx, int val);
        sample_data[idx*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(val);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: count captured samples and compare each completed window.
    int   cap_cnt = 0;
    logic cap_d   = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            cap_cnt = 0; cap_d = 1'b0;
        end else begin
            if (capture_en && sample_valid) cap_cnt++;
            if (cap_d && !capture_en) begin
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk("R9", "unexpected capture", 1, 0);
                    end else begin
                        cap_item_t it;
                        it = exp_q.pop_front();
                        chk(it.req, "trigger source", longint'(trig_src), longint'(it.src));
                        chk("R8", "captured samples", cap_cnt, it.len);
                    end
                end
                cap_cnt = 0;
            end
            cap_d = capture_en;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sample_valid = 1'b1; chan_sel = 2'd2; threshold = 10'd500;
        ext_trig_in = 1'b0; src_enable = 3'b111; cmd_valid = 1'b0; cmd_code = 2'd0;
        record_len = 30'd5; sample_data = '0;
        for (int i = 0; i < NUM_CH; i++) set_ch(i, 100);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "capture_en in reset", capture_en, 0);
        chk("R1", "done in reset", done, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "trig_src after reset", trig_src, 0);
        chk("R1", "sample_count after reset", sample_count, 0);

        // R2: software trigger while idle is ignored
        send_cmd(C_SW);
        repeat (3) @(negedge clk);
        chk("R2", "capture_en idle trigger", capture_en, 0);
        chk("R2", "done idle trigger", done, 0);

        // R5: software trigger
        send_cmd(C_ARM);
        expect_capture("R5", 2'd3, 5);
        send_cmd(C_SW);
        wait_done();
        chk("R5", "trig_src software", trig_src, 3);
        chk("R8", "final count", sample_count, 5);
        // R9: no new capture without re-arm
        send_cmd(C_SW);
        repeat (3) @(negedge clk);
        chk("R9", "capture_en unarmed", capture_en, 0);
        chk("R9", "done held", done, 1);

        // R3: level crossing, equality and unselected channel do not fire
        record_len = 30'd7;
        send_cmd(C_ARM);
        @(posedge clk); #1 set_ch(0, 1000); set_ch(2, 500);
        repeat (3) @(negedge clk);
        chk("R3", "capture_en equal/unselected", capture_en, 0);
        expect_capture("R3", 2'd1, 7);
        @(posedge clk); #1 set_ch(2, 501);
        @(posedge clk); #1;
        for (int i = 0; i < 30; i++) begin
            sample_valid = (i % 2 == 0);
            @(posedge clk); #1;
        end
        sample_valid = 1'b1;
        wait_done();
        chk("R3", "trig_src level", trig_src, 1);
        chk("R8", "count with gaps", sample_count, 7);

        // R6: masked sources have no effect
        src_enable = 3'b001;
        send_cmd(C_ARM);
        @(posedge clk); #1 ext_trig_in = 1'b1;
        repeat (5) @(posedge clk);
        #1 ext_trig_in = 1'b0;
        send_cmd(C_SW);
        repeat (3) @(negedge clk);
        chk("R6", "capture_en masked", capture_en, 0);
        chk("R6", "done masked", done, 0);
        // R10: abort from armed, then triggers ignored
        send_cmd(C_ABORT);
        src_enable = 3'b111;
        send_cmd(C_SW);
        repeat (3) @(negedge clk);
        chk("R10", "capture_en after abort", capture_en, 0);
        chk("R10", "trig_src after abort", trig_src, 0);

        // R4: external edge latency and code
        record_len = 30'd3;
        send_cmd(C_ARM);
        expect_capture("R4", 2'd2, 3);
        @(posedge clk); #1 ext_trig_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4", "capture_en after two edges", capture_en, 0);
        @(negedge clk);
        chk("R4", "capture_en after three edges", capture_en, 1);
        wait_done();
        chk("R4", "trig_src external", trig_src, 2);
        // R10: abort from done
        send_cmd(C_ABORT);
        @(negedge clk);
        chk("R10", "done after abort", done, 0);
        chk("R10", "count after abort", sample_count, 0);

        // R7: all three sources in one cycle
        @(posedge clk); #1 ext_trig_in = 1'b0; set_ch(2, 100);
        repeat (4) @(posedge clk);
        record_len = 30'd2;
        send_cmd(C_ARM);
        expect_capture("R7", 2'd3, 2);
        @(posedge clk); #1 ext_trig_in = 1'b1;
        repeat (2) @(posedge clk);
        #1 cmd_valid = 1'b1; cmd_code = C_SW; set_ch(2, 900);
        @(posedge clk); #1 cmd_valid = 1'b0; cmd_code = 2'd0;
        wait_done();
        chk("R7", "software beats external and level", trig_src, 3);

        // R7: external and level in one cycle
        @(posedge clk); #1 ext_trig_in = 1'b0; set_ch(2, 100);
        repeat (4) @(posedge clk);
        send_cmd(C_ARM);
        expect_capture("R7", 2'd2, 2);
        @(posedge clk); #1 ext_trig_in = 1'b1;
        repeat (2) @(posedge clk);
        #1 set_ch(2, 900);
        @(posedge clk); #1;
        wait_done();
        chk("R7", "external beats level", trig_src, 2);

        // R10: abort mid-capture
        @(posedge clk); #1 ext_trig_in = 1'b0; set_ch(2, 100);
        record_len = 30'd100;
        send_cmd(C_ARM);
        send_cmd(C_SW);
        repeat (5) @(negedge clk);
        chk("R10", "capturing before abort", capture_en, 1);
        send_cmd(C_ABORT);
        @(negedge clk);
        chk("R10", "capture_en after abort", capture_en, 0);
        chk("R10", "done after mid abort", done, 0);
        chk("R10", "count after mid abort", sample_count, 0);

        // R8: zero length acts as one
        record_len = 30'd0;
        send_cmd(C_ARM);
        expect_capture("R8", 2'd3, 1);
        send_cmd(C_SW);
        wait_done();
        chk("R8", "count for zero length", sample_count, 1);

        repeat (5) @(negedge clk);
        chk("R8", "pending scoreboard items", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule